// File: doc/BRIEF.md
# Two-Stage I2C Bus Clock Divider

This block derives the timing enables that an I2C controller needs from the system clock. It has two cascaded, separately programmable divider stages. A power-of-two prescaler produces a one-cycle sampling strobe at the system clock rate divided by 2^N. A second stage counts those strobes and toggles a free-running SCL output. That output is a 50% duty-cycle square wave whose frequency is the system clock divided by 10 × (M+1) × 2^N.

Both values live in one 8-bit control register. The register is loaded through a one-cycle write strobe and is always visible on a read-back port. With two stages, the sampling rate can stay at least ten times above the fastest SCL on the bus, so that START and STOP edges are never missed, while the master SCL is set much lower.

An enable input parks the block. While it is low, the strobe is held off and SCL sits at its idle high level.

Top module: `i2c_clkdiv`

## Requirements
- R1: After reset the control register reads 0x00 and SCL is high. With enable high and the register still at reset, the sampling strobe is high on every cycle.
- R2: The control register is written when `wr_en` is high at a rising clock edge. Bits [6:3] hold the 4-bit scalar M (0..15) and bits [2:0] hold the 3-bit exponent N (0..7). `ctrl_q` shows the stored value from the cycle after the write.
- R3: Bit 7 of the control register ignores writes and always reads 0.
- R4: Counting the first cycle after a write as cycle 1, with enable held high, `samp_en` is high exactly in the cycles whose number is a multiple of 2^N. Each strobe lasts one cycle.
- R5: With N = 0, `samp_en` is high on every enabled cycle.
- R6: SCL is high in the first cycle after a write and inverts after every 5 × (M+1) strobes. It is therefore a 50% square wave with a period of 10 × (M+1) × 2^N cycles. SCL changes only at the edge that ends a strobe cycle.
- R7: A write restarts both divider stages and drives SCL high, so nothing of the previous period is carried over.
- R8: While `en` is low, `samp_en` is low and SCL is high from the next cycle on. When `en` rises again, timing restarts exactly as after a write, with the re-enable cycle counted as cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider enable; low parks the block with SCL high |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_q | output | 8 | Control register read-back |
| samp_en | output | 1 | One-cycle bus sampling strobe |
| scl_out | output | 1 | Master-mode SCL output level |

## Verification
The bench compares every cycle of `samp_en` and `scl_out` against a closed-form model after each write. It covers the extreme settings N = 0 and M = 15 with N = 7. A design whose prescaler is off by one would shift every strobe by one cycle. A half-period counter that miscounts would break the 50% duty cycle or stretch the SCL period.

A rewrite in the middle of an SCL period checks that a design which kept its old counters would emit a shortened first half-period. A write of 0xFF checks that the reserved bit reads back as 0. An enable-low stretch checks that SCL parks high, and that timing restarts cleanly when the enable returns.

// File: rtl/i2c_clkdiv.sv
module i2c_clkdiv #(
  parameter int M_W = 4,
  parameter int N_W = 3,
  parameter int HALF_MUL = 5,
  localparam int REG_W = M_W + N_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic             samp_en,
  output logic             scl_out
);
  localparam int PRE_W = (1 << N_W) - 1;
  localparam int SC_W  = $clog2(HALF_MUL * (1 << M_W));

  logic [REG_W-1:0] ctrl;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [SC_W-1:0]  sc_cnt, half_lim;
  logic [M_W-1:0]   m_val;
  logic [N_W-1:0]   n_val;

  assign m_val    = ctrl[N_W +: M_W];
  assign n_val    = ctrl[N_W-1:0];
  assign pre_lim  = PRE_W'((32'd1 << n_val) - 32'd1);
  assign half_lim = SC_W'(HALF_MUL * (int'(m_val) + 1) - 1);
  assign samp_en  = en && (pre_cnt == pre_lim);
  assign ctrl_q   = ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en)
      ctrl <= {1'b0, wr_data[REG_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_cnt <= '0;
    else if (wr_en || !en || samp_en)
      pre_cnt <= '0;
    else
      pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_cnt  <= '0;
      scl_out <= 1'b1;
    end else if (wr_en || !en) begin
      sc_cnt  <= '0;
      scl_out <= 1'b1;
    end else if (samp_en) begin
      if (sc_cnt == half_lim) begin
        sc_cnt  <= '0;
        scl_out <= ~scl_out;
      end else begin
        sc_cnt <= sc_cnt + 1'b1;
      end
    end
  end
endmodule

module i2c_clkdiv_chk #(
  parameter int REG_W = 8,
  parameter int N_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             wr_en,
  input logic [REG_W-1:0] ctrl_q,
  input logic             samp_en,
  input logic             scl_out
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[REG_W-1] == 1'b0);

  p_n0_every_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ctrl_q[N_W-1:0] == '0) |-> samp_en);

  p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && !wr_en && ctrl_q[N_W-1:0] != '0) |=> !samp_en);

  p_scl_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_en && !samp_en) |=> $stable(scl_out));

  p_wr_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> scl_out);

  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> scl_out);
endmodule

bind i2c_clkdiv i2c_clkdiv_chk #(.REG_W(REG_W), .N_W(N_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
  .ctrl_q(ctrl_q), .samp_en(samp_en), .scl_out(scl_out)
);

// File: tb/i2c_clkdiv_tb_top.sv
module i2c_clkdiv_tb_top;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q;
  logic       samp_en, scl_out;

  int total = 0;
  int bad = 0;
  int cur_m = 0;
  int cur_n = 0;

  typedef struct {
    bit    s;
    bit    c;
    string rq;
  } exp_t;
  exp_t q[$];

  always #(CLK_T/2) clk = ~clk;

  i2c_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .samp_en(samp_en), .scl_out(scl_out)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (samp_en !== e.s || scl_out !== e.c) begin
        bad++;
        $display("FAIL %s: samp=%b scl=%b expected samp=%b scl=%b at %0t",
                 e.rq, samp_en, scl_out, e.s, e.c, $time);
      end
    end
  end

  task automatic push_run(int len, string rq);
    int p = 1 << cur_n;
    int h = 5 * (cur_m + 1);
    for (int c = 1; c <= len; c++) begin
      exp_t e;
      e.s  = (c % p) == 0;
      e.c  = (((c - 1) / p) / h) % 2 == 0;
      e.rq = rq;
      q.push_back(e);
    end
  endtask

  task automatic check_reg(logic [7:0] exp, string rq);
    total++;
    if (ctrl_q !== exp) begin
      bad++;
      $display("FAIL %s: ctrl_q=%h expected %h", rq, ctrl_q, exp);
    end
  endtask

  task automatic write_run(logic [7:0] val, int len, string rq);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = val;
    @(posedge clk); #1;
    wr_en = 1'b0;
    cur_m = int'(val[6:3]);
    cur_n = int'(val[2:0]);
    check_reg({1'b0, val[6:0]}, "R2");
    push_run(len, rq);
    repeat (len) @(posedge clk);
  endtask

  task automatic idle_run(int off_len, int on_len);
    @(posedge clk); #1;
    en = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < off_len; i++) begin
      exp_t e;
      e.s = 1'b0; e.c = 1'b1; e.rq = "R8";
      q.push_back(e);
    end
    repeat (off_len) @(posedge clk);
    #1 en = 1'b1;
    push_run(on_len, "R8");
    repeat (on_len) @(posedge clk);
  endtask

  initial begin
    #(CLK_T * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_reg(8'h00, "R1");
    push_run(40, "R1");
    repeat (40) @(posedge clk);

    write_run(8'hFF, 10, "R6");
    check_reg(8'h7F, "R3");

    write_run({1'b0, 4'd0, 3'd0}, 30, "R5");
    write_run({1'b0, 4'd1, 3'd2}, 100, "R4");
    write_run({1'b0, 4'd2, 3'd1}, 13, "R6");
    write_run({1'b0, 4'd0, 3'd1}, 60, "R7");
    write_run({1'b0, 4'd3, 3'd3}, 400, "R6");
    idle_run(20, 400);
    write_run({1'b1, 4'd15, 3'd7}, 21000, "R6");
    check_reg(8'h7F, "R3");

    @(posedge clk); #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule